// File: doc/BRIEF.md
# Block-Link Reply Generator

This block lives on the card side of a half-duplex block-transfer link. Upstream logic hands it one decoded frame at a time: the node address byte, the control byte, the length byte, the first information byte and a flag that marks the frame as damaged (bad check byte or bad parity). From that summary the block decides whether the link layer must answer on its own. If it must, it builds the reply frame and streams it to a byte transmitter through a valid/ready handshake.

Three kinds of reply are produced automatically: a zero-length receive-ready acknowledgement for each good chained information block, a zero-length receive-ready reply with its error bit set for any damaged frame, and the response form of an information-size or wait-extension request echoing the request's single data byte. Each reply goes back to the sender, whose address is formed by exchanging the two nibbles of the received address byte, and closes with an XOR check byte. The block also keeps the current maximum transmit block size, which an accepted information-size request overwrites. Every other frame is left to upper logic, which is told through a one-cycle pass-through strobe.

Top module: `blk_reply_responder`

## Requirements
- R1: The first byte of every reply is the received address byte with its high and low nibbles exchanged; the address value is never checked (0x21 gives 0x12, 0xA7 gives 0x7A).
- R2: A good frame whose control bit 7 is 0 and bit 5 (chain) is 1 gets the reply `addr', C, 0x00, check`, where C is 0x80 with bit 4 set equal to bit 6 (sequence) of the received control byte: 0x80 for sequence 0, 0x90 for sequence 1.
- R3: A frame presented with the bad flag gets the reply `addr', C, 0x00, check`, where C is 0x81 with bit 4 set equal to bit 6 of the received control byte; this takes priority over every other classification.
- R4: A good frame with control byte 0xC1 and length 1 gets the reply `addr', 0xE1, 0x01, d, check`, with d its data byte, and d becomes the stored block size from the cycle after the frame.
- R5: A good frame with control byte 0xC3 and length 1 gets the reply `addr', 0xE3, 0x01, d, check`, and leaves the stored block size unchanged.
- R6: The last byte of every reply equals the XOR of all reply bytes before it.
- R7: Reset sets the stored block size to 0x20, clears busy, the transmit valid and the pass-through strobe.
- R8: Reply bytes go out in order, one on each cycle where transmit valid and transmit ready are both high; while ready is low the byte and valid are held. Busy and valid rise in the cycle after the frame is taken and fall in the cycle after the check byte is accepted.
- R9: A good frame that matches none of R2, R4 and R5 (for example an unchained information block, control 0x00) raises the pass-through strobe for exactly one cycle, the cycle after the frame, and produces no reply.
- R10: A frame presented while busy is ignored: the reply in progress, the stored block size and the pass-through strobe are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | A decoded received frame is presented this cycle |
| frm_addr | input | 8 | Received address byte |
| frm_ctrl | input | 8 | Received control byte |
| frm_len | input | 8 | Received length byte |
| frm_data | input | 8 | First information byte of the received frame |
| frm_bad | input | 1 | Received frame failed its check byte or parity |
| tx_ready | input | 1 | Transmitter accepts the offered byte this cycle |
| tx_valid | output | 1 | A reply byte is offered |
| tx_byte | output | 8 | Reply byte offered to the transmitter |
| busy | output | 1 | A reply is being streamed |
| fwd_strobe | output | 1 | One-cycle pulse: frame left for upper logic |
| blk_size | output | 8 | Current maximum transmit block size |

## Verification
A frame is taken at a clock edge, and the first reply byte, busy, the pass-through strobe and a new block size are all visible one register later, at the following falling edge, where the bench samples them. Each later byte is due one cycle after the previous one was accepted, so the bench collects bytes only at falling edges where it has raised ready, and on stalled cycles confirms the offered byte is unchanged. Busy is checked low at the falling edge right after the check byte's acceptance edge, and the strobe is checked both in its cycle and one cycle later.

// File: rtl/blk_reply_pkg.sv
package blk_reply_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  // Control byte bit positions used for classification and reply forming
  localparam int CB_KIND_HI  = 7;
  localparam int CB_SEQ_IN   = 6;
  localparam int CB_CHAIN    = 5;
  localparam int CB_SUP_RESP = 5;

  localparam logic [BYTE_W-1:0] SUP_SIZE_REQ = 8'hC1;
  localparam logic [BYTE_W-1:0] SUP_WAIT_REQ = 8'hC3;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_ACK  = 2'd1,
    RK_ERR  = 2'd2,
    RK_SUP  = 2'd3
  } rkind_t;

  function automatic logic [BYTE_W-1:0] nib_swap(input logic [BYTE_W-1:0] b);
    return {b[NIB_W-1:0], b[BYTE_W-1:NIB_W]};
  endfunction

endpackage

// File: rtl/reply_classify.sv
module reply_classify
  import blk_reply_pkg::*;
(
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] ctrl,
  input  logic [BYTE_W-1:0] len,
  input  logic [BYTE_W-1:0] data,
  input  logic              bad,
  output rkind_t            kind,
  output logic [BYTE_W-1:0] r_addr,
  output logic [BYTE_W-1:0] r_ctrl,
  output logic [BYTE_W-1:0] r_len,
  output logic [BYTE_W-1:0] r_data,
  output logic              r_has_data,
  output logic              size_req
);

  logic seq;
  logic sup_req;

  always_comb begin
    seq     = ctrl[CB_SEQ_IN];
    sup_req = ((ctrl == SUP_SIZE_REQ) || (ctrl == SUP_WAIT_REQ)) &&
              (len == BYTE_W'(1));
    r_addr     = nib_swap(addr);
    kind       = RK_NONE;
    r_ctrl     = '0;
    r_len      = '0;
    r_data     = '0;
    r_has_data = 1'b0;
    size_req   = 1'b0;
    if (bad) begin
      kind   = RK_ERR;
      r_ctrl = {3'b100, seq, 4'b0001};
    end else if (!ctrl[CB_KIND_HI] && ctrl[CB_CHAIN]) begin
      kind   = RK_ACK;
      r_ctrl = {3'b100, seq, 4'b0000};
    end else if (sup_req) begin
      kind       = RK_SUP;
      r_ctrl     = ctrl | (BYTE_W'(1) << CB_SUP_RESP);
      r_len      = len;
      r_data     = data;
      r_has_data = 1'b1;
      size_req   = (ctrl == SUP_SIZE_REQ);
    end
  end

endmodule

// File: rtl/reply_serializer.sv
module reply_serializer
  import blk_reply_pkg::*;
#(
  parameter int MAX_BYTES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] b_addr,
  input  logic [BYTE_W-1:0] b_ctrl,
  input  logic [BYTE_W-1:0] b_len,
  input  logic [BYTE_W-1:0] b_data,
  input  logic              has_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              busy
);

  localparam int IW = $clog2(MAX_BYTES);
  localparam logic [IW-1:0] LAST_SHORT = IW'(MAX_BYTES - 2);
  localparam logic [IW-1:0] LAST_LONG  = IW'(MAX_BYTES - 1);

  logic [BYTE_W-1:0] frame_q [MAX_BYTES];
  logic [IW-1:0]     idx_q;
  logic [IW-1:0]     last_q;
  logic              busy_q;
  logic [BYTE_W-1:0] lrc;

  assign lrc = b_addr ^ b_ctrl ^ b_len ^ (has_data ? b_data : '0);

  // Frame storage, no reset, so it maps to plain registers or distributed RAM
  always_ff @(posedge clk) begin
    if (start && !busy_q) begin
      frame_q[0] <= b_addr;
      frame_q[1] <= b_ctrl;
      frame_q[2] <= b_len;
      frame_q[3] <= has_data ? b_data : lrc;
      frame_q[4] <= lrc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        last_q <= has_data ? LAST_LONG : LAST_SHORT;
      end
    end else if (tx_ready) begin
      if (idx_q == last_q) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  assign busy     = busy_q;
  assign tx_valid = busy_q;
  assign tx_byte  = frame_q[idx_q];

  // R8
  held_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tx_valid && tx_ready));

endmodule

// File: rtl/blk_size_store.sv
module blk_size_store
  import blk_reply_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_SIZE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] size_q
);

  always_ff @(posedge clk) begin
    if (rst)       size_q <= RESET_SIZE;
    else if (load) size_q <= din;
  end

  // R7
  size_reset_chk: assert property (@(posedge clk)
    rst |=> (size_q == RESET_SIZE));

  // R4
  size_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(size_q));

  // R4
  size_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (size_q == $past(din)));

endmodule

// File: rtl/blk_reply_responder.sv
module blk_reply_responder
  import blk_reply_pkg::*;
#(
  parameter int                MAX_BYTES  = 5,
  parameter logic [BYTE_W-1:0] RESET_SIZE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic [BYTE_W-1:0] frm_addr,
  input  logic [BYTE_W-1:0] frm_ctrl,
  input  logic [BYTE_W-1:0] frm_len,
  input  logic [BYTE_W-1:0] frm_data,
  input  logic              frm_bad,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              busy,
  output logic              fwd_strobe,
  output logic [BYTE_W-1:0] blk_size
);

  rkind_t            kind;
  logic [BYTE_W-1:0] r_addr, r_ctrl, r_len, r_data;
  logic              r_has_data;
  logic              size_req;
  logic              accept;
  logic              fwd_q;

  reply_classify u_cls (
    .addr       (frm_addr),
    .ctrl       (frm_ctrl),
    .len        (frm_len),
    .data       (frm_data),
    .bad        (frm_bad),
    .kind       (kind),
    .r_addr     (r_addr),
    .r_ctrl     (r_ctrl),
    .r_len      (r_len),
    .r_data     (r_data),
    .r_has_data (r_has_data),
    .size_req   (size_req)
  );

  assign accept = frm_valid && !busy;

  reply_serializer #(.MAX_BYTES(MAX_BYTES)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .start    (accept && (kind != RK_NONE)),
    .b_addr   (r_addr),
    .b_ctrl   (r_ctrl),
    .b_len    (r_len),
    .b_data   (r_data),
    .has_data (r_has_data),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .busy     (busy)
  );

  blk_size_store #(.RESET_SIZE(RESET_SIZE)) u_size (
    .clk    (clk),
    .rst    (rst),
    .load   (accept && size_req),
    .din    (frm_data),
    .size_q (blk_size)
  );

  always_ff @(posedge clk) begin
    if (rst) fwd_q <= 1'b0;
    else     fwd_q <= accept && (kind == RK_NONE);
  end

  assign fwd_strobe = fwd_q;

  // R9
  fwd_no_reply_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_strobe |-> !busy);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && frm_valid) |=> !fwd_strobe);

  // R9
  fwd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_strobe |=> !fwd_strobe || $past(frm_valid));

endmodule

// File: tb/sim_blk_reply_responder.sv
module sim_blk_reply_responder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_valid = 1'b0;
  logic [7:0] frm_addr = '0, frm_ctrl = '0, frm_len = '0, frm_data = '0;
  logic       frm_bad = 1'b0;
  logic       tx_ready = 1'b0;
  logic       tx_valid, busy, fwd_strobe;
  logic [7:0] tx_byte, blk_size;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [7:0] got [0:7];
  int got_n;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_reply_responder u0 (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_addr(frm_addr),
    .frm_ctrl(frm_ctrl), .frm_len(frm_len), .frm_data(frm_data),
    .frm_bad(frm_bad), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .busy(busy), .fwd_strobe(fwd_strobe),
    .blk_size(blk_size)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  // Presents a frame for one cycle; returns at the falling edge after it is taken
  task automatic send_frame(input logic [7:0] a, input logic [7:0] c,
                            input logic [7:0] l, input logic [7:0] d, input bit bad);
    @(negedge clk);
    frm_valid = 1'b1; frm_addr = a; frm_ctrl = c; frm_len = l;
    frm_data = d; frm_bad = bad;
    @(negedge clk);
    frm_valid = 1'b0; frm_bad = 1'b0;
  endtask

  // Collects a reply; stall=1 drops ready on every other cycle
  task automatic get_reply(input bit stall, input string req);
    logic [7:0] held;
    bit have_held = 0;
    got_n = 0;
    for (int c = 0; c < 40; c++) begin
      if (!tx_valid) break;
      if (have_held) begin
        check(tx_byte == held, req, tx_byte, held);
        have_held = 0;
      end
      tx_ready = !stall || (c % 2 == 1);
      if (tx_ready) begin
        if (got_n < 8) got[got_n] = tx_byte;
        got_n++;
      end else begin
        held = tx_byte;
        have_held = 1;
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check(!busy, req, busy, 0);
  endtask

  task automatic expect_reply(input string req, input int n,
                              input logic [7:0] e0, input logic [7:0] e1,
                              input logic [7:0] e2, input logic [7:0] e3,
                              input logic [7:0] e4);
    logic [7:0] e [0:4];
    logic [7:0] x = '0;
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3; e[4] = e4;
    check(got_n == n, {req, " length"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++) begin
      check(got[i] == e[i], req, got[i], e[i]);
      if (i < n - 1) x = x ^ got[i];
    end
    // R6 check byte is XOR of the preceding bytes
    if (got_n == n) check(got[n-1] == x, "R6", got[n-1], x);
  endtask

  task automatic t_reset();
    check(!busy && !tx_valid, "R7 idle", {busy, tx_valid}, 0);
    check(!fwd_strobe, "R7 strobe", fwd_strobe, 0);
    check(blk_size == 8'h20, "R7 size", blk_size, 8'h20);
  endtask

  task automatic t_chain_ack();
    send_frame(8'h21, 8'h20, 8'h05, 8'h11, 0);
    check(busy && tx_valid, "R8 busy rise", {busy, tx_valid}, 3);
    get_reply(0, "R2 seq0");
    expect_reply("R2 seq0", 4, 8'h12, 8'h80, 8'h00, 8'h92, 8'h00);
    send_frame(8'h21, 8'h60, 8'h05, 8'h11, 0);
    get_reply(1, "R8 stall");
    expect_reply("R2 seq1", 4, 8'h12, 8'h90, 8'h00, 8'h82, 8'h00);
    // R1 arbitrary address, nibbles exchanged, no check
    send_frame(8'hA7, 8'h20, 8'h01, 8'h00, 0);
    get_reply(0, "R1");
    expect_reply("R1", 4, 8'h7A, 8'h80, 8'h00, 8'hFA, 8'h00);
  endtask

  task automatic t_error();
    send_frame(8'h21, 8'h00, 8'h02, 8'h00, 1);
    get_reply(0, "R3");
    expect_reply("R3 seq0", 4, 8'h12, 8'h81, 8'h00, 8'h93, 8'h00);
    // bad flag wins over a size request
    send_frame(8'h21, 8'hC1, 8'h01, 8'h40, 1);
    get_reply(1, "R3");
    expect_reply("R3 seq1", 4, 8'h12, 8'h91, 8'h00, 8'h83, 8'h00);
    check(blk_size == 8'h20, "R3 size kept", blk_size, 8'h20);
  endtask

  task automatic t_size_req();
    send_frame(8'h21, 8'hC1, 8'h01, 8'h58, 0);
    check(blk_size == 8'h58, "R4 size", blk_size, 8'h58);
    get_reply(0, "R4");
    expect_reply("R4", 5, 8'h12, 8'hE1, 8'h01, 8'h58, 8'hAA);
  endtask

  task automatic t_wait_req();
    send_frame(8'h21, 8'hC3, 8'h01, 8'h05, 0);
    get_reply(1, "R5");
    expect_reply("R5", 5, 8'h12, 8'hE3, 8'h01, 8'h05, 8'hF5);
    check(blk_size == 8'h58, "R5 size kept", blk_size, 8'h58);
  endtask

  task automatic t_forward();
    send_frame(8'h21, 8'h00, 8'h03, 8'h77, 0);
    check(fwd_strobe, "R9 strobe", fwd_strobe, 1);
    check(!busy && !tx_valid, "R9 no reply", {busy, tx_valid}, 0);
    @(negedge clk);
    check(!fwd_strobe, "R9 one cycle", fwd_strobe, 0);
    // size request with wrong length is also passed up
    send_frame(8'h21, 8'hC1, 8'h02, 8'h33, 0);
    check(fwd_strobe && !busy, "R9 len2", {fwd_strobe, busy}, 2);
    check(blk_size == 8'h58, "R9 size kept", blk_size, 8'h58);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    send_frame(8'h21, 8'h20, 8'h01, 8'h00, 0);
    send_frame(8'h21, 8'hC1, 8'h01, 8'h30, 0);
    check(!fwd_strobe, "R10 strobe", fwd_strobe, 0);
    check(blk_size == 8'h58, "R10 size", blk_size, 8'h58);
    send_frame(8'h21, 8'h00, 8'h01, 8'h00, 0);
    check(!fwd_strobe, "R10 strobe2", fwd_strobe, 0);
    get_reply(0, "R10");
    expect_reply("R10", 4, 8'h12, 8'h80, 8'h00, 8'h92, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_chain_ack();
    t_error();
    t_size_req();
    t_wait_req();
    t_forward();
    t_busy_ignore();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(blk_size == 8'h20, "R7 re-reset", blk_size, 8'h20);
    done = 1;
    finish_run();
  end

endmodule